// File: doc/BRIEF.md
# Column-Parallel Pixel Row Sequencer

This controller scans a pixel matrix one row at a time while every column works in parallel. Each column ends in a shared, auto-zeroed comparator. For the selected row it asserts a one-hot row select, which also serves the analog-only columns. It then drives the row-wide pixel switches and the comparator phase controls. Every pixel access runs a calibration phase first, then a dead cycle, then a readout phase, and ends with a single-cycle latch strobe.

On the strobe cycle the comparator outputs of all discriminated columns are captured into one hit word. That word is offered on a valid/ready output together with the row index. The scan moves to the next row only after the word has been taken. A mode input chooses a 6-clock or an 8-clock pixel cycle. The mode is sampled when scanning starts and again each time the row counter wraps, so one frame never mixes both timings.

Top module: `pixel_row_sequencer`

## Requirements
- R1: A synchronous reset, or the time before a start pulse, leaves the sequencer idle: row_sel is zero, all switch and comparator controls are low, out_valid and frame_end are low.
- R2: A start pulse in idle begins the scan at row 0 in the next cycle. Rows follow in increasing order. While a row's pixel cycle runs, row_sel has exactly bit r set for row r, and row_sel is zero otherwise.
- R3: In short mode (long_mode=0) a pixel cycle is 6 clocks, numbered 0 to 5. pix_cal and cmp_autozero are high in clocks 0-1, pix_smp1 in clock 0, nothing in clock 2, pix_rd and cmp_compare in clocks 3-4, pix_smp2 in clock 3, and cmp_strobe in clock 5.
- R4: In long mode (long_mode=1) a pixel cycle is 8 clocks. Calibration runs in clocks 0-2, with pix_smp1 in clock 0. Clock 3 is empty. Readout runs in clocks 4-6, with pix_smp2 in clock 4. cmp_strobe is in clock 7.
- R5: The calibration and readout controls are never high together, and at least one clock with neither separates them.
- R6: cmp_strobe is a one-clock pulse. hit_in sampled at the end of the strobe clock appears on out_hits, with the row index on out_row and out_valid high, in the next clock.
- R7: While out_valid is high and out_ready is low, out_hits and out_row hold, row_sel and all controls stay low, and no new row starts. The next row's cycle starts in the clock after the accepting edge.
- R8: Accepting row ROWS-1 wraps the scan to row 0 and raises frame_end for exactly one clock, namely the first clock of row 0's cycle.
- R9: A change of long_mode takes effect only at the start of the scan or at a frame wrap. Rows within a frame keep the cycle length the frame started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin scanning when idle |
| long_mode | input | 1 | 1 selects the 8-clock pixel cycle, 0 the 6-clock cycle |
| hit_in | input | HIT_COLS | Comparator outputs, one per discriminated column |
| out_ready | input | 1 | Consumer accepts the hit word |
| row_sel | output | ROWS | One-hot row select shared by all columns |
| pix_cal | output | 1 | Pixel calibration switch |
| pix_smp1 | output | 1 | First sample switch |
| pix_smp2 | output | 1 | Second sample switch |
| pix_rd | output | 1 | Pixel readout switch |
| cmp_autozero | output | 1 | Comparator calibration phase |
| cmp_compare | output | 1 | Comparator readout phase |
| cmp_strobe | output | 1 | Comparator latch pulse |
| out_valid | output | 1 | Hit word available |
| out_hits | output | HIT_COLS | Captured hit word |
| out_row | output | ROW_W | Row the hit word belongs to |
| frame_end | output | 1 | One-clock pulse when the scan wraps to row 0 |

## Verification
The first pixel clock comes one cycle after the start edge, or one cycle after the accepting edge. Clock k of the cycle then follows k edges later. The strobe lands 5 edges after clock 0 in short mode and 7 edges after it in long mode. out_valid and the captured word follow one edge after the strobe, and frame_end shows in the clock after the edge that accepts the last row. The bench drives and samples on falling edges and walks each pixel cycle clock by clock against a table of expected control values. It changes hit_in on every clock except the strobe clock, so a capture in any other clock shows up as a mismatch.

// File: rtl/pixel_row_sequencer.sv
module pixel_row_sequencer #(
  parameter int ROWS      = 128,
  parameter int HIT_COLS  = 24,
  parameter int SHORT_CAL = 2,
  parameter int SHORT_RD  = 2,
  parameter int LONG_CAL  = 3,
  parameter int LONG_RD   = 3,
  localparam int ROW_W    = $clog2(ROWS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                long_mode,
  input  logic [HIT_COLS-1:0] hit_in,
  input  logic                out_ready,
  output logic [ROWS-1:0]     row_sel,
  output logic                pix_cal,
  output logic                pix_smp1,
  output logic                pix_smp2,
  output logic                pix_rd,
  output logic                cmp_autozero,
  output logic                cmp_compare,
  output logic                cmp_strobe,
  output logic                out_valid,
  output logic [HIT_COLS-1:0] out_hits,
  output logic [ROW_W-1:0]    out_row,
  output logic                frame_end
);

  localparam int MAX_LEN = LONG_CAL + LONG_RD + 2;
  localparam int PH_W    = $clog2(MAX_LEN + 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  logic             busy, long_q;
  logic [PH_W-1:0]  ph;
  logic [ROW_W-1:0] row;

  wire              active   = busy & ~out_valid;
  wire [PH_W-1:0]   cal_len  = long_q ? PH_W'(LONG_CAL) : PH_W'(SHORT_CAL);
  wire [PH_W-1:0]   rd_len   = long_q ? PH_W'(LONG_RD)  : PH_W'(SHORT_RD);
  wire [PH_W-1:0]   rd_start = cal_len + PH_W'(1);
  wire [PH_W-1:0]   rd_end   = rd_start + rd_len;

  assign pix_cal      = active && (ph < cal_len);
  assign pix_smp1     = active && (ph == '0);
  assign pix_rd       = active && (ph >= rd_start) && (ph < rd_end);
  assign pix_smp2     = active && (ph == rd_start);
  assign cmp_autozero = pix_cal;
  assign cmp_compare  = pix_rd;
  assign cmp_strobe   = active && (ph == rd_end);
  assign row_sel      = active ? (ROWS'(1) << row) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      long_q    <= 1'b0;
      ph        <= '0;
      row       <= '0;
      out_valid <= 1'b0;
      out_hits  <= '0;
      out_row   <= '0;
      frame_end <= 1'b0;
    end else begin
      frame_end <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          ph     <= '0;
          row    <= '0;
          long_q <= long_mode;
        end
      end else if (out_valid) begin
        if (out_ready) begin
          out_valid <= 1'b0;
          if (row == LAST_ROW) begin
            row       <= '0;
            frame_end <= 1'b1;
            long_q    <= long_mode;
          end else begin
            row <= row + ROW_W'(1);
          end
        end
      end else if (cmp_strobe) begin
        out_valid <= 1'b1;
        out_hits  <= hit_in;
        out_row   <= row;
        ph        <= '0;
      end else begin
        ph <= ph + PH_W'(1);
      end
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (row_sel == '0) && !pix_cal && !pix_rd && !cmp_strobe && !out_valid);

  assert_row_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_sel));

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (rst)
    !(pix_cal && pix_rd));

  assert_gap_before_rd_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(pix_rd) |-> !$past(pix_cal));

  assert_strobe_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    cmp_strobe |=> !cmp_strobe && out_valid);

  assert_hold_output_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_hits) && $stable(out_row) && (row_sel == '0));

  assert_frame_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> !frame_end);

endmodule

// File: tb/pixel_row_sequencer_tb.sv
module pixel_row_sequencer_tb_top;
  localparam int ROWS = 128;
  localparam int HC   = 24;

  logic clk = 0, rst = 1, start = 0, long_mode = 0, out_ready = 0;
  logic [HC-1:0] hit_in = '0;
  logic [ROWS-1:0] row_sel;
  logic pix_cal, pix_smp1, pix_smp2, pix_rd, cmp_autozero, cmp_compare, cmp_strobe;
  logic out_valid, frame_end;
  logic [HC-1:0] out_hits;
  logic [6:0] out_row;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pixel_row_sequencer dut_i (
    .clk(clk), .rst(rst), .start(start), .long_mode(long_mode), .hit_in(hit_in),
    .out_ready(out_ready), .row_sel(row_sel), .pix_cal(pix_cal), .pix_smp1(pix_smp1),
    .pix_smp2(pix_smp2), .pix_rd(pix_rd), .cmp_autozero(cmp_autozero),
    .cmp_compare(cmp_compare), .cmp_strobe(cmp_strobe), .out_valid(out_valid),
    .out_hits(out_hits), .out_row(out_row), .frame_end(frame_end));

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [HC-1:0] pat_of(input int r);
    return HC'(24'h5A3C96 ^ (r * 24'h01F3A7));
  endfunction

  // expected {cal, smp1, smp2, rd, strobe}
  function automatic logic [4:0] exp_ctrl(input bit lng, input int i);
    logic c, s1, s2, r, l;
    if (!lng) begin
      c = (i < 2); s1 = (i == 0); r = (i == 3 || i == 4); s2 = (i == 3); l = (i == 5);
    end else begin
      c = (i < 3); s1 = (i == 0); r = (i >= 4 && i <= 6); s2 = (i == 4); l = (i == 7);
    end
    return {c, s1, s2, r, l};
  endfunction

  function automatic bit quiet();
    return (row_sel == '0) && !pix_cal && !pix_smp1 && !pix_smp2 && !pix_rd &&
           !cmp_autozero && !cmp_compare && !cmp_strobe;
  endfunction

  // entered on the falling edge inside clock 0 of a row's pixel cycle
  task automatic do_row(input bit lng, input int r, input int stall);
    int len = lng ? 8 : 6;
    string req = lng ? "R4" : "R3";
    logic [HC-1:0] p = pat_of(r);
    for (int i = 0; i < len; i++) begin
      logic [4:0] e = exp_ctrl(lng, i);
      chk({pix_cal, pix_smp1, pix_smp2, pix_rd, cmp_strobe} == e, req,
          {pix_cal, pix_smp1, pix_smp2, pix_rd, cmp_strobe}, e);
      chk(cmp_autozero == pix_cal && cmp_compare == pix_rd, req,
          {cmp_autozero, cmp_compare}, {pix_cal, pix_rd});
      chk(!(pix_cal && pix_rd), "R5", {pix_cal, pix_rd}, 0);
      chk(row_sel == (ROWS'(1) << r), "R2", row_sel, ROWS'(1) << r);
      chk(!out_valid, "R6", out_valid, 0);
      hit_in = (i == len - 1) ? p : ~p;
      @(negedge clk);
    end
    hit_in = ~p;
    chk(out_valid && out_hits == p && out_row == 7'(r), "R6", {out_valid, out_row, out_hits}, {1'b1, 7'(r), p});
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      hit_in = hit_in ^ 24'h111111;
      chk(out_valid && out_hits == p && out_row == 7'(r), "R7", {out_valid, out_row, out_hits}, {1'b1, 7'(r), p});
      chk(quiet(), "R7", row_sel, 0);
    end
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    chk(!out_valid, "R7", out_valid, 0);
    chk(frame_end == (r == ROWS - 1), "R8", frame_end, (r == ROWS - 1));
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    chk(quiet() && !out_valid && !frame_end, "R1", {out_valid, frame_end, row_sel}, 0);
    rst = 0;
    repeat (4) @(negedge clk);
    chk(quiet() && !out_valid, "R1", row_sel, 0);
  endtask

  task automatic t_start_short();
    long_mode = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    for (int r = 0; r < 4; r++) do_row(0, r, 0);
  endtask

  task automatic t_stall();
    do_row(0, 4, 6);
  endtask

  task automatic t_mode_frame();
    long_mode = 1;
    for (int r = 5; r < ROWS; r++) do_row(0, r, (r == 60) ? 2 : 0);
    for (int r = 0; r < 3; r++) do_row(1, r, 0);
    chk(1'b1, "R9", 0, 0);
  endtask

  task automatic t_reset_midscan();
    repeat (2) @(negedge clk);
    rst = 1;
    @(negedge clk);
    chk(quiet() && !out_valid, "R1", row_sel, 0);
    rst = 0;
    repeat (5) @(negedge clk);
    chk(quiet() && !out_valid && !frame_end, "R1", row_sel, 0);
    long_mode = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    do_row(0, 0, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_start_short();
    t_stall();
    t_mode_frame();
    t_reset_midscan();
    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end
endmodule